// File: doc/BRIEF.md
# Horizontal Sync Phase Detector

This block is the digital front end of a line-locked clock loop. It samples a horizontal sync input and the divided clock feedback on a fast sampling clock. It delays each sync falling edge by a fixed number of sampling cycles to form the reference event. It then compares that reference with the rising edge of the feedback and requests current from an external charge pump. An up request raises the oscillator frequency and a down request lowers it.

A two-bit mode input selects among three modes. Normal mode runs the detector. Fast-lock mode also sends a single-cycle resynchronisation request to the divider whenever the phase error grows too wide. Coast mode parks the detector so that the pump output stays in high impedance while sync is missing. An active-low lock flag reports lock, and it goes high for at least a line after any out-of-tolerance error.

Top module: `hsync_phase_det`

## Requirements
- R1: The reference event occurs DLY_CYC sampling cycles after the cycle in which a falling sync edge is sampled. A new falling edge restarts the delay, and the earlier edge then produces no reference.
- R2: When the feedback rising edge is sampled E cycles after the reference, pump_up_o is high for exactly E cycles and pump_dn_o stays low. Positive error means the feedback lags.
- R3: When the feedback rising edge is sampled E cycles before the reference, pump_dn_o is high for exactly E cycles and pump_up_o stays low.
- R4: When both events fall in the same cycle, neither request is raised. pump_en_o is high exactly when one of the two requests is high.
- R5: Mode encoding: mode_i = 2'b00 selects normal, 2'b01 selects fast-lock, and 2'b10 or 2'b11 selects coast.
- R6: In coast mode, sync and feedback edges raise no request. pump_en_o stays low, lock_no keeps its value, and its hold timer is frozen.
- R7: After reset, lock_no is high until the first comparison whose error width is at most TOL_CYC cycles.
- R8: An error pulse wider than TOL_CYC cycles drives lock_no high. It stays high for LINE_CYC cycles after the last out-of-tolerance cycle and then falls, provided an in-tolerance comparison has already been seen.
- R9: In fast-lock mode, an error pulse wider than FAST_CYC cycles gives exactly one cycle of resync_o. resync_o never rises in normal or coast mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Horizontal sync; its falling edge is the reference |
| fb_i | input | 1 | Divided clock feedback; its rising edge is compared |
| mode_i | input | 2 | Operating mode (see R5) |
| pump_up_o | output | 1 | Source-current request |
| pump_dn_o | output | 1 | Sink-current request |
| pump_en_o | output | 1 | Pump driver enable; low means high impedance |
| lock_no | output | 1 | Lock flag, low when locked |
| resync_o | output | 1 | One-cycle divider resync request in fast-lock mode |

## Verification
The delayed reference and the feedback edge can land in the same sampling cycle. In that case the two detector flags set together and must clear one cycle later without any pump request. This is provoked by placing the feedback edge exactly DLY_CYC cycles after the sync fall, and it is judged by counting request and enable cycles, which must be zero. The same comparison must also count as in tolerance and release the lock flag. A second coincidence arises when an error pulse crosses both the lock tolerance and the fast-lock threshold within one pulse. The bench provokes it with wide errors in fast-lock mode and checks that the lock flag and a single resync pulse both appear.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
  typedef logic [1:0] mode_t;
  localparam mode_t MODE_NORM = 2'b00;
  localparam mode_t MODE_FAST = 2'b01;

  function automatic logic is_coast(mode_t m);
    return m[1];
  endfunction
endpackage

// File: rtl/hpd_ref_delay.sv
module hpd_ref_delay #(
  parameter int DLY_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic ref_o
);
  localparam int DW = $clog2(DLY_CYC + 1);
  localparam logic [DW-1:0] DLY_LD = DW'(DLY_CYC);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic          sync_q;
  logic [DW-1:0] cnt_q;
  logic          fall;

  assign fall  = sync_q & ~sync_i;
  assign ref_o = (cnt_q == ONE) & ~fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_i;
      if (fall)               cnt_q <= DLY_LD;
      else if (cnt_q != '0)   cnt_q <= cnt_q - ONE;
    end
  end

  assert_delay_restart_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> cnt_q == DLY_LD);
  assert_delay_expire_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o |=> cnt_q == '0);
endmodule

// File: rtl/hpd_core.sv
module hpd_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic coast_i,
  input  logic ref_i,
  input  logic fbk_i,
  output logic up_o,
  output logic dn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else if (coast_i || (up_o && dn_o)) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else begin
      up_o <= up_o | ref_i;
      dn_o <= dn_o | fbk_i;
    end
  end

  assert_common_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o && dn_o) |=> (!up_o && !dn_o));
  assert_coast_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coast_i |=> (!up_o && !dn_o));
  assert_up_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o && !dn_o && !coast_i) |=> up_o);
endmodule

// File: rtl/hpd_lock_mon.sv
module hpd_lock_mon #(
  parameter int TOL_CYC  = 4,
  parameter int FAST_CYC = 16,
  parameter int LINE_CYC = 15888
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic coast_i,
  input  logic fast_i,
  input  logic single_i,
  input  logic both_i,
  output logic lock_no,
  output logic resync_o
);
  localparam int MAXC = ((TOL_CYC > FAST_CYC) ? TOL_CYC : FAST_CYC) + 1;
  localparam int EW   = $clog2(MAXC + 1);
  localparam int HW   = $clog2(LINE_CYC + 1);
  localparam logic [EW-1:0] E_TOL  = EW'(TOL_CYC);
  localparam logic [EW-1:0] E_FAST = EW'(FAST_CYC);
  localparam logic [EW-1:0] E_MAX  = EW'(MAXC);
  localparam logic [HW-1:0] H_LD   = HW'(LINE_CYC);

  logic [EW-1:0] err_q;
  logic [HW-1:0] hold_q;
  logic          seen_ok_q;
  logic          over;

  assign over     = single_i && (err_q >= E_TOL);
  assign resync_o = fast_i && single_i && (err_q == E_FAST);
  assign lock_no  = !seen_ok_q || (hold_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q     <= '0;
      hold_q    <= '0;
      seen_ok_q <= 1'b0;
    end else if (!coast_i) begin
      if (single_i)  err_q <= (err_q == E_MAX) ? err_q : err_q + EW'(1);
      else           err_q <= '0;
      if (both_i && err_q <= E_TOL) seen_ok_q <= 1'b1;
      if (over)                hold_q <= H_LD;
      else if (hold_q != '0)   hold_q <= hold_q - HW'(1);
    end
  end

  assert_lock_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_no) |-> $past(over));
  assert_coast_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coast_i && $past(coast_i)) |-> $stable(lock_no));
  assert_resync_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_o |=> !resync_o);
endmodule

// File: rtl/hsync_phase_det.sv
module hsync_phase_det
  import hpd_pkg::*;
#(
  parameter int DLY_CYC  = 50,
  parameter int TOL_CYC  = 4,
  parameter int FAST_CYC = 16,
  parameter int LINE_CYC = 15888
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_i,
  input  logic       fb_i,
  input  logic [1:0] mode_i,
  output logic       pump_up_o,
  output logic       pump_dn_o,
  output logic       pump_en_o,
  output logic       lock_no,
  output logic       resync_o
);
  logic fb_q, fb_rise, ref_ev, up, dn, coast, fast;

  assign coast   = is_coast(mode_i);
  assign fast    = (mode_i == MODE_FAST);
  assign fb_rise = fb_i & ~fb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fb_q <= 1'b0;
    else         fb_q <= fb_i;
  end

  hpd_ref_delay #(.DLY_CYC(DLY_CYC)) u_dly (
    .clk_i, .rst_ni, .sync_i, .ref_o(ref_ev)
  );

  hpd_core u_core (
    .clk_i, .rst_ni, .coast_i(coast), .ref_i(ref_ev), .fbk_i(fb_rise),
    .up_o(up), .dn_o(dn)
  );

  // masked during the common-clear cycle so a zero error yields no request
  assign pump_up_o = up & ~dn;
  assign pump_dn_o = dn & ~up;
  assign pump_en_o = up ^ dn;

  hpd_lock_mon #(.TOL_CYC(TOL_CYC), .FAST_CYC(FAST_CYC), .LINE_CYC(LINE_CYC)) u_lock (
    .clk_i, .rst_ni, .coast_i(coast), .fast_i(fast),
    .single_i(up ^ dn), .both_i(up & dn),
    .lock_no, .resync_o
  );

  assert_coast_hiz_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coast && $past(coast)) |-> !pump_en_o);
  assert_no_resync_normal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_NORM) |-> !resync_o);
endmodule

// File: tb/hsync_phase_det_tb_top.sv
`timescale 1ns/1ps
module hsync_phase_det_tb_top;
  localparam int DLY = 6, TOL = 2, FST = 5, LINE = 120, NV = 9, SPAN = 80;

  // feedback offset, mode, up cycles, dn cycles, resync pulses, lock_no at end
  localparam int V_J [NV] = '{6, 8, 3, 13, 10, 0, 6, 12, 1};
  localparam int V_M [NV] = '{0, 0, 0, 1,  1,  1, 1, 3,  0};
  localparam int V_UP[NV] = '{0, 2, 0, 7,  4,  0, 0, 0,  0};
  localparam int V_DN[NV] = '{0, 0, 3, 0,  0,  6, 0, 0,  5};
  localparam int V_RS[NV] = '{0, 0, 0, 1,  0,  1, 0, 0,  0};
  localparam int V_LK[NV] = '{0, 0, 1, 1,  1,  1, 0, 0,  1};

  logic clk = 1'b0, rst_ni = 1'b0, sync_i = 1'b1, fb_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic pump_up_o, pump_dn_o, pump_en_o, lock_no, resync_o;
  int n_chk = 0, n_fail = 0;
  int c_up, c_dn, c_rs, c_bad;

  always #2 clk = ~clk;

  hsync_phase_det #(.DLY_CYC(DLY), .TOL_CYC(TOL), .FAST_CYC(FST), .LINE_CYC(LINE)) dut_i (
    .clk_i(clk), .rst_ni, .sync_i, .fb_i, .mode_i,
    .pump_up_o, .pump_dn_o, .pump_en_o, .lock_no, .resync_o
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one line: sync falls at k=0 (and again at k=3 if restart), feedback rises at k=j
  task automatic run_line(input int j, input logic [1:0] m, input bit restart);
    c_up = 0; c_dn = 0; c_rs = 0; c_bad = 0;
    mode_i = m;
    for (int k = 0; k < SPAN; k++) begin
      @(negedge clk);
      c_up += int'(pump_up_o);
      c_dn += int'(pump_dn_o);
      c_rs += int'(resync_o);
      if (pump_en_o != (pump_up_o | pump_dn_o)) c_bad++;
      sync_i = restart ? !((k < 1) || (k >= 3 && k < 20)) : !(k < 20);
      fb_i   = (k >= j) && (k < j + 10);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset lock_no", int'(lock_no), 1);
    check("R4 reset pump_en", int'(pump_en_o), 0);
    check("R9 reset resync", int'(resync_o), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_line(V_J[v], V_M[v], 1'b0);
      check($sformatf("R2 up width v%0d", v), c_up, V_UP[v]);
      check($sformatf("R3 dn width v%0d", v), c_dn, V_DN[v]);
      check($sformatf("R9 resync v%0d", v), c_rs, V_RS[v]);
      check($sformatf("R4 enable v%0d", v), c_bad, 0);
      check($sformatf("R8 lock_no v%0d", v), int'(lock_no), V_LK[v]);
    end

    // R6 coast: hold timer frozen, lock flag kept
    mode_i = 2'b10;
    repeat (200) @(negedge clk);
    check("R6 lock frozen in coast", int'(lock_no), 1);
    check("R6 no enable in coast", int'(pump_en_o), 0);
    mode_i = 2'b00;
    repeat (LINE + 10) @(negedge clk);
    check("R8 lock released after line", int'(lock_no), 0);

    // R1 restart: second fall 3 cycles later; feedback aligned to it
    run_line(9, 2'b00, 1'b1);
    check("R1 restart up", c_up, 0);
    check("R1 restart dn", c_dn, 0);
    check("R1 restart lock", int'(lock_no), 0);

    // R5 fast-lock encoding vs normal with equal wide lag
    run_line(DLY + FST + 2, 2'b01, 1'b0);
    check("R5 fast encoding resync", c_rs, 1);
    run_line(DLY + FST + 2, 2'b00, 1'b0);
    check("R5 normal encoding resync", c_rs, 0);
    check("R2 lag width normal", c_up, FST + 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule